// File: doc/BRIEF.md
# Timer Register Write Bridge Across Clock Domains

This block carries processor writes from a fast clock domain into three registers that live in a slow timer clock domain: the timer count, the compare value and the timer control word. A write names one of the three registers with a two-bit select and supplies the data. The bridge captures the data in a holding register of that channel, flags the channel busy, and hands the value across to the slow domain. The value lands in its destination on the second rising edge of the slow clock.

Each channel has its own holding register, request toggle and busy bit, so transfers to different registers overlap freely. The busy bits are readable by the processor so that software can tell when a value has landed. Software must not write a channel again while it is busy. Such a write is dropped, and a sticky overrun bit records it.

While a count or compare transfer is pending, a compare-suppress level tells the timer's compare logic to stay quiet. A reset on either clock domain's reset input empties every channel. The fast clock must run at more than four times the slow clock.

Top module: `xdom_reg_bridge`

## Requirements
- R1: An accepted write reaches its destination output on the second rising edge of the slow clock after the fast edge that accepted it. After the first of those slow edges the destination still shows its previous value.
- R2: The busy bit of a channel is 1 right after the fast edge that accepts a write to it. Bit 0 is count (select 0), bit 1 is compare (select 1) and bit 2 is control (select 2).
- R3: The busy bit returns to 0 on the second rising fast edge after the slow edge that committed the value. It still reads 1 after the first of those fast edges.
- R4: Writes to different channels in consecutive fast cycles both complete, each with its own data, and neither disturbs the other.
- R5: The compare-suppress output is 1 whenever the count or compare channel is busy. It is 0 when only the control channel is busy or nothing is pending.
- R6: A write to a busy channel is ignored and its destination keeps the first value. The channel's overrun bit becomes 1 and stays 1 until reset, and the overrun bits of the other channels stay 0.
- R7: A write with select 3 starts no transfer, sets no busy bit and changes no destination.
- R8: Driving either reset input low at once clears every busy bit, every overrun bit and every destination value to 0, even with a transfer pending.
- R9: Each commit raises that channel's update pulse in the slow domain for exactly one slow clock cycle, on the same edge as the new value. No other channel's pulse rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Fast processor clock |
| rst_cpu_n | input | 1 | Active-low asynchronous reset from the fast domain |
| clk_tmr | input | 1 | Slow timer clock |
| rst_tmr_n | input | 1 | Active-low asynchronous reset from the slow domain |
| wr_en | input | 1 | Write strobe, sampled on clk_cpu |
| wr_sel | input | 2 | Target: 0 count, 1 compare, 2 control, 3 none |
| wr_data | input | W | Write data |
| busy | output | 3 | Per-channel update-busy bits (fast domain) |
| overrun | output | 3 | Sticky per-channel write-while-busy bits (fast domain) |
| cmp_hold | output | 1 | Compare-suppress level, high while count or compare is busy |
| cnt_value | output | W | Committed count value (slow domain) |
| cmp_value | output | W | Committed compare value (slow domain) |
| ctrl_value | output | W | Committed control value (slow domain) |
| upd_pulse | output | 3 | One-slow-cycle commit pulse per channel |

## Verification
Suppose a channel's request toggle and returned acknowledge disagree when they should not. The busy bit then sticks at 1 or falls too early, and the destination either never updates or takes a stale holding value. Both show within two slow edges plus two fast edges of the write.

If a holding register is shared or overwritten by mistake, it shows on the destination output as a wrong value after overlapping writes or after a write to a busy channel. A reset path that misses one domain leaves a nonzero busy or value output at the instant the other reset is asserted.

// File: rtl/xdb_pkg.sv
`timescale 1ns/1ps
package xdb_pkg;
  localparam int NREG        = 3;
  localparam int SEL_W       = 2;
  localparam int IDX_COUNT   = 0;
  localparam int IDX_COMPARE = 1;
  localparam int IDX_CONTROL = 2;
endpackage

// File: rtl/xdb_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assertion, synchronous release of an active-low reset.
module xdb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/xdb_sync2.sv
`timescale 1ns/1ps
// Two-flop level synchronizer.
module xdb_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      out_q  <= '0;
    end else begin
      meta_q <= d;
      out_q  <= meta_q;
    end
  end

  assign q = out_q;
endmodule

// File: rtl/xdb_chan.sv
`timescale 1ns/1ps
// One register channel: fast-side holding register and request toggle,
// slow-side toggle detection and commit, acknowledge returned to fast side.
module xdb_chan #(
  parameter int W = 8
) (
  input  logic         clk_f,
  input  logic         rst_f_n,
  input  logic         clk_s,
  input  logic         rst_s_n,
  input  logic         hit,
  input  logic [W-1:0] data,
  output logic         busy,
  output logic         overrun,
  output logic [W-1:0] dst,
  output logic         upd
);
  // fast domain state
  logic [W-1:0] hold_q, hold_d;
  logic         req_q, req_d;
  logic         ovr_q, ovr_d;
  logic         ack_f;
  logic         accept;

  // slow domain state
  logic         s1_q, s1_d;
  logic         s2_q, s2_d;
  logic [W-1:0] dst_q, dst_d;
  logic         upd_q, upd_d;
  logic         commit;

  assign busy   = req_q ^ ack_f;
  assign accept = hit & ~busy;

  always_comb begin
    hold_d = hold_q;
    req_d  = req_q;
    ovr_d  = ovr_q | (hit & busy);
    if (accept) begin
      hold_d = data;
      req_d  = ~req_q;
    end
  end

  always_ff @(posedge clk_f or negedge rst_f_n) begin
    if (!rst_f_n) begin
      hold_q <= '0;
      req_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      req_q  <= req_d;
      ovr_q  <= ovr_d;
    end
  end

  // acknowledge toggle returns through two fast flops
  xdb_sync2 #(.W(1)) u_ack_sync (
    .clk   (clk_f),
    .rst_n (rst_f_n),
    .d     (s2_q),
    .q     (ack_f)
  );

  // slow side: commit on the edge where the second stage takes the new toggle
  assign commit = s1_q ^ s2_q;

  always_comb begin
    s1_d  = req_q;
    s2_d  = s1_q;
    upd_d = commit;
    dst_d = dst_q;
    if (commit) dst_d = hold_q;
  end

  always_ff @(posedge clk_s or negedge rst_s_n) begin
    if (!rst_s_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      dst_q <= '0;
      upd_q <= 1'b0;
    end else begin
      s1_q  <= s1_d;
      s2_q  <= s2_d;
      dst_q <= dst_d;
      upd_q <= upd_d;
    end
  end

  assign overrun = ovr_q;
  assign dst     = dst_q;
  assign upd     = upd_q;
endmodule

// File: rtl/xdom_reg_bridge.sv
`timescale 1ns/1ps
module xdom_reg_bridge
  import xdb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk_cpu,
  input  logic             rst_cpu_n,
  input  logic             clk_tmr,
  input  logic             rst_tmr_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [W-1:0]     wr_data,
  output logic [NREG-1:0]  busy,
  output logic [NREG-1:0]  overrun,
  output logic             cmp_hold,
  output logic [W-1:0]     cnt_value,
  output logic [W-1:0]     cmp_value,
  output logic [W-1:0]     ctrl_value,
  output logic [NREG-1:0]  upd_pulse
);
  logic           rst_any_n;
  logic           rst_f_n;
  logic           rst_s_n;
  logic [NREG-1:0] hit;
  logic [W-1:0]   dst [NREG];

  // a reset in either domain empties both sides
  assign rst_any_n = rst_cpu_n & rst_tmr_n;

  xdb_rst_sync #(.STAGES(2)) u_rst_f (
    .clk     (clk_cpu),
    .arst_n  (rst_any_n),
    .rst_n_o (rst_f_n)
  );

  xdb_rst_sync #(.STAGES(2)) u_rst_s (
    .clk     (clk_tmr),
    .arst_n  (rst_any_n),
    .rst_n_o (rst_s_n)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_ch
    assign hit[i] = wr_en && (wr_sel == SEL_W'(i));

    xdb_chan #(.W(W)) u_ch (
      .clk_f   (clk_cpu),
      .rst_f_n (rst_f_n),
      .clk_s   (clk_tmr),
      .rst_s_n (rst_s_n),
      .hit     (hit[i]),
      .data    (wr_data),
      .busy    (busy[i]),
      .overrun (overrun[i]),
      .dst     (dst[i]),
      .upd     (upd_pulse[i])
    );
  end

  assign cmp_hold   = busy[IDX_COUNT] | busy[IDX_COMPARE];
  assign cnt_value  = dst[IDX_COUNT];
  assign cmp_value  = dst[IDX_COMPARE];
  assign ctrl_value = dst[IDX_CONTROL];
endmodule

// File: rtl/xdb_checker.sv
`timescale 1ns/1ps
module xdb_checker
  import xdb_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk_f,
  input logic             clk_s,
  input logic             rst_f_n,
  input logic             rst_s_n,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [NREG-1:0]  busy,
  input logic [NREG-1:0]  overrun,
  input logic             cmp_hold,
  input logic [W-1:0]     cnt_value,
  input logic [W-1:0]     cmp_value,
  input logic [W-1:0]     ctrl_value,
  input logic [NREG-1:0]  upd_pulse
);
  for (genvar i = 0; i < NREG; i++) begin : g_a
    // R2
    a_r2_busy_set: assert property (@(posedge clk_f) disable iff (!rst_f_n)
      (wr_en && wr_sel == SEL_W'(i) && !busy[i]) |=> busy[i]);
    // R6
    a_r6_overrun_set: assert property (@(posedge clk_f) disable iff (!rst_f_n)
      (wr_en && wr_sel == SEL_W'(i) && busy[i]) |=> overrun[i]);
    // R6
    a_r6_overrun_sticky: assert property (@(posedge clk_f) disable iff (!rst_f_n)
      overrun[i] |=> overrun[i]);
    // R9
    a_r9_pulse_single: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      upd_pulse[i] |=> !upd_pulse[i]);
  end

  // R7
  a_r7_sel_none: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    (wr_en && wr_sel == SEL_W'(3) && busy == '0) |=> busy == '0);
  // R5
  a_r5_hold_on_cmp: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    (wr_en && wr_sel == SEL_W'(IDX_COMPARE) && !busy[IDX_COMPARE]) |=> cmp_hold);
  // R1
  a_r1_cnt_only_on_pulse: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    (cnt_value != $past(cnt_value)) |-> upd_pulse[IDX_COUNT]);
  // R1
  a_r1_cmp_only_on_pulse: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    (cmp_value != $past(cmp_value)) |-> upd_pulse[IDX_COMPARE]);
  // R1
  a_r1_ctrl_only_on_pulse: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    (ctrl_value != $past(ctrl_value)) |-> upd_pulse[IDX_CONTROL]);
endmodule

bind xdom_reg_bridge xdb_checker #(.W(W)) u_chk (
  .clk_f      (clk_cpu),
  .clk_s      (clk_tmr),
  .rst_f_n    (rst_f_n),
  .rst_s_n    (rst_s_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .busy       (busy),
  .overrun    (overrun),
  .cmp_hold   (cmp_hold),
  .cnt_value  (cnt_value),
  .cmp_value  (cmp_value),
  .ctrl_value (ctrl_value),
  .upd_pulse  (upd_pulse)
);

// File: tb/sim_xdom_reg_bridge.sv
`timescale 1ns/1ps
module sim_xdom_reg_bridge;
  localparam int W = 8;

  logic         clk_cpu = 1'b0;
  logic         clk_tmr = 1'b0;
  logic         rst_cpu_n;
  logic         rst_tmr_n;
  logic         wr_en;
  logic [1:0]   wr_sel;
  logic [W-1:0] wr_data;
  logic [2:0]   busy;
  logic [2:0]   overrun;
  logic         cmp_hold;
  logic [W-1:0] cnt_value;
  logic [W-1:0] cmp_value;
  logic [W-1:0] ctrl_value;
  logic [2:0]   upd_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4  clk_cpu = ~clk_cpu;   // 125 MHz
  always #24 clk_tmr = ~clk_tmr;   // slow clock, 6x slower

  xdom_reg_bridge #(.W(W)) u0 (
    .clk_cpu, .rst_cpu_n, .clk_tmr, .rst_tmr_n,
    .wr_en, .wr_sel, .wr_data,
    .busy, .overrun, .cmp_hold,
    .cnt_value, .cmp_value, .ctrl_value, .upd_pulse
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] dst_of(input int sel);
    case (sel)
      0:       return cnt_value;
      1:       return cmp_value;
      default: return ctrl_value;
    endcase
  endfunction

  task automatic do_write(input int sel, input logic [W-1:0] d);
    @(negedge clk_cpu);
    wr_en   = 1'b1;
    wr_sel  = 2'(sel);
    wr_data = d;
    @(posedge clk_cpu);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && busy != 3'b000; k++) @(posedge clk_cpu);
    #1;
    chk(busy == 3'b000, "R3 channel drains", int'(busy), 0);
  endtask

  task automatic do_reset();
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    rst_cpu_n = 1'b0; rst_tmr_n = 1'b0;
    repeat (3) @(posedge clk_tmr);
    @(negedge clk_tmr);
    rst_cpu_n = 1'b1; rst_tmr_n = 1'b1;
    repeat (4) @(posedge clk_tmr);
    #2;
  endtask

  // full latency walk of one write; checks R1, R2, R3, R5, R9
  task automatic write_tracked(input int sel, input logic [W-1:0] d);
    logic [W-1:0] prev = dst_of(sel);
    bit exp_hold = (sel < 2);
    do_write(sel, d);
    chk(busy[sel] == 1'b1, "R2 busy after accept", int'(busy[sel]), 1);
    chk(cmp_hold == exp_hold, "R5 suppress while pending", int'(cmp_hold), int'(exp_hold));
    @(posedge clk_tmr); #2;
    chk(dst_of(sel) == prev, "R1 unchanged after first slow edge", int'(dst_of(sel)), int'(prev));
    chk(upd_pulse == 3'b000, "R9 no pulse before commit", int'(upd_pulse), 0);
    @(posedge clk_tmr); #2;
    chk(dst_of(sel) == d, "R1 committed on second slow edge", int'(dst_of(sel)), int'(d));
    chk(upd_pulse == 3'(1 << sel), "R9 pulse on own channel", int'(upd_pulse), 1 << sel);
    @(posedge clk_cpu); #1;
    chk(busy[sel] == 1'b1, "R3 busy after first fast edge", int'(busy[sel]), 1);
    @(posedge clk_cpu); #1;
    chk(busy[sel] == 1'b0, "R3 busy clear after second fast edge", int'(busy[sel]), 0);
    chk(cmp_hold == 1'b0, "R5 suppress released", int'(cmp_hold), 0);
    @(posedge clk_tmr); #2;
    chk(upd_pulse == 3'b000, "R9 pulse lasts one slow cycle", int'(upd_pulse), 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(busy == 3'b000, "R8 busy after reset", int'(busy), 0);
    chk(overrun == 3'b000, "R8 overrun after reset", int'(overrun), 0);
    chk(cnt_value == 0 && cmp_value == 0 && ctrl_value == 0, "R8 values after reset",
        int'({cnt_value, cmp_value, ctrl_value}), 0);
    chk(cmp_hold == 1'b0, "R5 idle suppress", int'(cmp_hold), 0);
  endtask

  task automatic t_single_writes();
    write_tracked(0, 8'hA5);
    write_tracked(1, 8'h3C);
    write_tracked(2, 8'h81);
    write_tracked(0, 8'h00);
    write_tracked(1, 8'hFF);
  endtask

  task automatic t_overlap();
    do_write(0, 8'h12);
    do_write(1, 8'h34);
    chk(busy == 3'b011, "R4 both pending", int'(busy), 3);
    do_write(2, 8'h56);
    wait_idle();
    repeat (2) @(posedge clk_tmr); #2;
    chk(cnt_value == 8'h12, "R4 count kept", int'(cnt_value), 'h12);
    chk(cmp_value == 8'h34, "R4 compare kept", int'(cmp_value), 'h34);
    chk(ctrl_value == 8'h56, "R4 control kept", int'(ctrl_value), 'h56);
  endtask

  task automatic t_overrun();
    do_write(0, 8'h11);
    do_write(0, 8'h22);
    chk(overrun == 3'b001, "R6 overrun on count only", int'(overrun), 1);
    wait_idle();
    repeat (2) @(posedge clk_tmr); #2;
    chk(cnt_value == 8'h11, "R6 second write dropped", int'(cnt_value), 'h11);
    write_tracked(0, 8'h33);
    chk(overrun == 3'b001, "R6 overrun sticky", int'(overrun), 1);
  endtask

  task automatic t_sel_none();
    logic [W-1:0] a = cnt_value, b = cmp_value, c = ctrl_value;
    do_write(3, 8'h77);
    chk(busy == 3'b000, "R7 no busy for select 3", int'(busy), 0);
    repeat (3) @(posedge clk_tmr); #2;
    chk(cnt_value == a && cmp_value == b && ctrl_value == c, "R7 no destination change",
        int'({cnt_value, cmp_value, ctrl_value}), int'({a, b, c}));
    chk(upd_pulse == 3'b000, "R7 no pulse", int'(upd_pulse), 0);
  endtask

  task automatic t_reset_mid(input bit slow_side);
    do_write(1, 8'h5A);
    @(posedge clk_tmr); #2;
    if (slow_side) rst_tmr_n = 1'b0; else rst_cpu_n = 1'b0;
    #1;
    chk(busy == 3'b000, "R8 busy cleared by reset", int'(busy), 0);
    chk(overrun == 3'b000, "R8 overrun cleared", int'(overrun), 0);
    chk(cnt_value == 0 && cmp_value == 0 && ctrl_value == 0, "R8 values cleared",
        int'({cnt_value, cmp_value, ctrl_value}), 0);
    repeat (2) @(posedge clk_tmr);
    @(negedge clk_tmr);
    rst_cpu_n = 1'b1; rst_tmr_n = 1'b1;
    repeat (4) @(posedge clk_tmr); #2;
    chk(cmp_value == 0, "R8 pending write gone after reset", int'(cmp_value), 0);
    write_tracked(1, 8'hC3);
  endtask

  initial begin : watchdog
    for (int k = 0; k < 150000 && !done; k++) @(posedge clk_cpu);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    t_reset_state();
    t_single_writes();
    t_overlap();
    t_overrun();
    t_sel_none();
    t_reset_mid(1'b1);
    t_reset_mid(1'b0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule